// File: doc/BRIEF.md
# Register-Mask Stack Save/Restore Sequencer

This block copies a chosen group of processor registers onto a byte-wide memory stack, or reloads them from it. A start pulse carries an 8-bit selection mask, a direction flag (save or restore) and a flag that picks the system or the user stack. The block then walks the selected registers one byte per cycle. It reads their values through a register read port when saving, and returns rebuilt values through a register write port when restoring. When the last byte has moved it reports the final stack pointer for write-back and raises a one-cycle done pulse. Interrupt entry can use the same block with every mask bit set.

The registers are a mix of 8-bit and 16-bit values, and they sit at fixed mask positions. A 16-bit value takes two bytes on the stack, with the high byte at the lower address. One mask position does not name a fixed register: it names whichever stack pointer is not the one being walked. Saving works down the mask from bit 7 and restoring works up from bit 0, so a restore with the same mask undoes a save.

Top module: `stack_mask_seq`

## Requirements
- R1: Mask bit b selects slot b: bit 0 CC, 1 A, 2 B, 3 DP, 4 X, 5 Y, 6 the other stack pointer, 7 PC. Slots 0-3 are one byte and slots 4-7 are two bytes. Register ids on rd_id and wr_id are CC=0, A=1, B=2, DP=3, X=4, Y=5, USP=6, PC=7, SSP=8.
- R2: A save visits the set mask bits from 7 down to 0. A restore visits them from 0 up to 7.
- R3: Each saved byte first lowers the pointer by one and is then written at the new pointer. A one-byte register supplies bits 7:0 of rd_data.
- R4: A two-byte register is saved low byte first, at pointer-1, then high byte at pointer-2. The pointer drops by 2 and the value is stored big-endian.
- R5: Each restored byte is read at the pointer, and the pointer then rises by one. mem_rdata is valid in the cycle after the read. The high byte of a two-byte register is at the lower address. wr_en pulses in the cycle after the register's last read. One-byte values are zero-extended on wr_data.
- R6: Exactly one memory access is made per cycle while busy. done is high exactly n+1 cycles after the start cycle, where n is the number of bytes selected.
- R7: On the system stack (on_user=0) slot 6 is USP (id 6). On the user stack (on_user=1) slot 6 is SSP (id 8).
- R8: Pointer and address arithmetic wrap modulo 65536.
- R9: A zero mask makes no memory access. It gives done in the cycle after start and reports the pointer unchanged.
- R10: done lasts one cycle. In that cycle sp_upd_en is high, sp_upd_user names the walked stack and sp_upd_val is its final pointer.
- R11: A start pulse that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| pull | input | 1 | 1 restores from stack, 0 saves to stack |
| on_user | input | 1 | 1 walks the user stack, 0 the system stack |
| mask | input | 8 | Register selection mask |
| sp_sys_in | input | 16 | Current system stack pointer |
| sp_usr_in | input | 16 | Current user stack pointer |
| rd_id | output | 4 | Register being read for a save |
| rd_data | input | 16 | Value of register rd_id, same cycle |
| wr_en | output | 1 | Register write strobe during restore |
| wr_id | output | 4 | Register being written |
| wr_data | output | 16 | Restored register value |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Read byte, one cycle after the read |
| sp_upd_en | output | 1 | Stack pointer write-back strobe |
| sp_upd_user | output | 1 | 1 write-back goes to USP, 0 to SSP |
| sp_upd_val | output | 16 | Final stack pointer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
If the walking pointer is wrong, the very next access shows it on mem_addr as a broken one-step address sequence. Later it shows again as a wrong sp_upd_val. A fault in the remaining-mask or half-register state moves the done pulse away from start plus n+1 cycles. It also corrupts the stored image or swaps bytes, so comparing memory after a save and the register file after a restore exposes it within that same transfer. A wrong slot-6 choice or a wrong direction shows up as a foreign register value at a known stack address.

// File: rtl/stkseq_pkg.sv
package stkseq_pkg;

   typedef enum logic [3:0] {
      RID_CC  = 4'd0,
      RID_A   = 4'd1,
      RID_B   = 4'd2,
      RID_DP  = 4'd3,
      RID_X   = 4'd4,
      RID_Y   = 4'd5,
      RID_USP = 4'd6,
      RID_PC  = 4'd7,
      RID_SSP = 4'd8
   } rid_e;

   localparam int FIRST_WIDE_SLOT = 4;
   localparam int OTHER_SP_SLOT   = 6;

   // slot number to register id; slot 6 names the pointer not being walked
   function automatic rid_e slot_rid(input logic [2:0] slot, input logic on_user);
      if (slot == 3'(OTHER_SP_SLOT))
         return on_user ? RID_SSP : RID_USP;
      return rid_e'({1'b0, slot});
   endfunction

endpackage

// File: rtl/stkseq_pick.sv
module stkseq_pick #(
   parameter int N          = 8,
   parameter bit HIGH_FIRST = 1'b1,
   localparam int IW        = $clog2(N)
) (
   input  logic [N-1:0]  bits,
   output logic [IW-1:0] idx
);

   generate
      if (HIGH_FIRST) begin : g_high
         always_comb begin
            idx = '0;
            for (int i = 0; i < N; i++)
               if (bits[i]) idx = IW'(i);
         end
      end else begin : g_low
         always_comb begin
            idx = '0;
            for (int i = N - 1; i >= 0; i--)
               if (bits[i]) idx = IW'(i);
         end
      end
   endgenerate

endmodule

// File: rtl/stkseq_step.sv
module stkseq_step #(
   parameter int AW = 16
) (
   input  logic [AW-1:0] ptr,
   input  logic          pull,
   output logic [AW-1:0] acc_addr,
   output logic [AW-1:0] nxt_ptr
);

   always_comb begin
      if (pull) begin
         acc_addr = ptr;
         nxt_ptr  = ptr + AW'(1);
      end else begin
         acc_addr = ptr - AW'(1);
         nxt_ptr  = ptr - AW'(1);
      end
   end

endmodule

// File: rtl/stack_mask_seq.sv
module stack_mask_seq
   import stkseq_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int WORD_W = 16,
   parameter int MASK_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              pull,
   input  logic              on_user,
   input  logic [MASK_W-1:0] mask,
   input  logic [WORD_W-1:0] sp_sys_in,
   input  logic [WORD_W-1:0] sp_usr_in,
   output logic [3:0]        rd_id,
   input  logic [WORD_W-1:0] rd_data,
   output logic              wr_en,
   output logic [3:0]        wr_id,
   output logic [WORD_W-1:0] wr_data,
   output logic              mem_en,
   output logic              mem_we,
   output logic [WORD_W-1:0] mem_addr,
   output logic [BYTE_W-1:0] mem_wdata,
   input  logic [BYTE_W-1:0] mem_rdata,
   output logic              sp_upd_en,
   output logic              sp_upd_user,
   output logic [WORD_W-1:0] sp_upd_val,
   output logic              busy,
   output logic              done
);

   localparam int SLOT_W = $clog2(MASK_W);
   localparam int EXT_W  = WORD_W - BYTE_W;

   initial begin
      assert (WORD_W == 2 * BYTE_W) else $error("WORD_W must be two bytes");
      assert (MASK_W == 8) else $error("slot map needs an 8-bit mask");
   end

   // sequencing state
   logic              busy_q, pull_q, user_q, half_q, done_q;
   logic [MASK_W-1:0] rem_q;
   logic [WORD_W-1:0] ptr_q;
   // read-return stage
   logic              pv_q, p_hi_q, p_wide_q;
   logic [3:0]        p_id_q;
   logic [BYTE_W-1:0] hold_q;

   logic [SLOT_W-1:0] slot_hi, slot_lo, slot;
   logic              wide, byte_hi, fin_reg, last;
   logic [MASK_W-1:0] rem_nxt;
   logic [WORD_W-1:0] acc_addr, nxt_ptr;
   rid_e              cur_id;

   stkseq_pick #(.N(MASK_W), .HIGH_FIRST(1'b1)) u_pick_hi (.bits(rem_q), .idx(slot_hi));
   stkseq_pick #(.N(MASK_W), .HIGH_FIRST(1'b0)) u_pick_lo (.bits(rem_q), .idx(slot_lo));

   stkseq_step #(.AW(WORD_W)) u_step (
      .ptr(ptr_q), .pull(pull_q), .acc_addr(acc_addr), .nxt_ptr(nxt_ptr)
   );

   always_comb begin
      slot    = pull_q ? slot_lo : slot_hi;
      wide    = (slot >= SLOT_W'(FIRST_WIDE_SLOT));
      cur_id  = slot_rid(slot, user_q);
      // save: second byte is the high one; restore: first byte is the high one
      byte_hi = pull_q ? (wide & ~half_q) : half_q;
      fin_reg = ~wide | half_q;
      rem_nxt = fin_reg ? (rem_q & ~(MASK_W'(1) << slot)) : rem_q;
      last    = busy_q & fin_reg & (rem_nxt == '0);
   end

   assign rd_id     = cur_id;
   assign mem_en    = busy_q;
   assign mem_we    = busy_q & ~pull_q;
   assign mem_addr  = acc_addr;
   assign mem_wdata = byte_hi ? rd_data[WORD_W-1:BYTE_W] : rd_data[BYTE_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         pull_q   <= 1'b0;
         user_q   <= 1'b0;
         half_q   <= 1'b0;
         done_q   <= 1'b0;
         rem_q    <= '0;
         ptr_q    <= '0;
         pv_q     <= 1'b0;
         p_hi_q   <= 1'b0;
         p_wide_q <= 1'b0;
         p_id_q   <= '0;
         hold_q   <= '0;
      end else begin
         done_q <= 1'b0;
         pv_q   <= 1'b0;
         if (!busy_q) begin
            if (start) begin
               busy_q <= (mask != '0);
               done_q <= (mask == '0);
               pull_q <= pull;
               user_q <= on_user;
               rem_q  <= mask;
               half_q <= 1'b0;
               ptr_q  <= on_user ? sp_usr_in : sp_sys_in;
            end
         end else begin
            ptr_q  <= nxt_ptr;
            half_q <= wide & ~half_q;
            rem_q  <= rem_nxt;
            if (last) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
            if (pull_q) begin
               pv_q     <= 1'b1;
               p_hi_q   <= byte_hi;
               p_wide_q <= wide;
               p_id_q   <= cur_id;
            end
         end
         if (pv_q && p_hi_q) hold_q <= mem_rdata;
      end
   end

   assign wr_en       = pv_q & ~p_hi_q;
   assign wr_id       = p_id_q;
   assign wr_data     = p_wide_q ? {hold_q, mem_rdata} : {{EXT_W{1'b0}}, mem_rdata};
   assign sp_upd_en   = done_q;
   assign sp_upd_user = user_q;
   assign sp_upd_val  = ptr_q;
   assign busy        = busy_q;
   assign done        = done_q;

   // R3: consecutive save bytes step the address down by one
   a_r3_save_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - WORD_W'(1)));

   // R5: consecutive restore reads step the address up by one
   a_r5_load_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && !mem_we && $past(mem_en && !mem_we)) |-> (mem_addr == $past(mem_addr) + WORD_W'(1)));

   // R5: a register write always follows a memory read
   a_r5_wr_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(mem_en && !mem_we));

   // R9: an idle start with an empty mask finishes next cycle with no access
   a_r9_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && mask == '0) |=> (done && !mem_en));

   // R10: done is a single-cycle pulse unless a fresh start was taken
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done || $past(start)));

   // R11: direction and stack choice hold steady while busy
   a_r11_hold_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(pull_q) && $stable(user_q)));

endmodule

// File: tb/stack_mask_seq_bench.sv
module stack_mask_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, pull = 1'b0, on_user = 1'b0;
   logic [7:0]  mask = '0;
   logic [3:0]  rd_id, wr_id;
   logic [15:0] rd_data, wr_data, mem_addr, sp_upd_val;
   logic        wr_en, mem_en, mem_we, sp_upd_en, sp_upd_user, busy, done;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = '0;

   logic [15:0] regs [0:8];
   logic [7:0]  mem  [0:255];

   logic        poke_en = 1'b0;
   logic [3:0]  poke_id = '0;
   logic [15:0] poke_val = '0;
   logic        log_clr = 1'b0;
   int          acc_cnt = 0;
   logic [15:0] first_addr = '0, last_addr = '0;

   int n_chk = 0, n_bad = 0;

   always #5 clk = ~clk;

   stack_mask_seq u_stack_mask_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .pull(pull), .on_user(on_user),
      .mask(mask), .sp_sys_in(regs[8]), .sp_usr_in(regs[6]),
      .rd_id(rd_id), .rd_data(rd_data), .wr_en(wr_en), .wr_id(wr_id), .wr_data(wr_data),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .sp_upd_en(sp_upd_en), .sp_upd_user(sp_upd_user),
      .sp_upd_val(sp_upd_val), .busy(busy), .done(done)
   );

   assign rd_data = (rd_id <= 4'd8) ? regs[rd_id] : 16'h0;

   always @(posedge clk) begin
      if (poke_en) regs[poke_id] <= poke_val;
      if (wr_en) regs[wr_id] <= wr_data;
      if (sp_upd_en) regs[sp_upd_user ? 6 : 8] <= sp_upd_val;
      if (mem_en && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      if (mem_en && !mem_we) mem_rdata <= mem[mem_addr[7:0]];
      if (log_clr) acc_cnt <= 0;
      else if (mem_en) begin
         if (acc_cnt == 0) first_addr <= mem_addr;
         last_addr <= mem_addr;
         acc_cnt <= acc_cnt + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic poke(input int id, input logic [15:0] val);
      @(negedge clk);
      poke_en = 1'b1; poke_id = 4'(id); poke_val = val;
      @(negedge clk);
      poke_en = 1'b0;
   endtask

   // runs one transfer; returns cycles from start cycle to done
   task automatic run_op(input bit p, input bit u, input logic [7:0] m,
                         input bit inject, output int cyc);
      @(negedge clk);
      log_clr = 1'b1;
      @(negedge clk);
      log_clr = 1'b0;
      start = 1'b1; pull = p; on_user = u; mask = m;
      @(negedge clk);
      start = 1'b0;
      cyc = 1;
      if (inject && !done) begin
         start = 1'b1; mask = 8'hFF; pull = ~p; on_user = ~u;
         @(negedge clk);
         start = 1'b0;
         cyc++;
      end
      while (!done && cyc < 100) begin
         @(negedge clk);
         cyc++;
      end
      @(negedge clk);
      chk(done == 1'b0, "R10 done width", int'(done), 0);
   endtask

   function automatic int nbytes(input logic [7:0] m);
      int s = 0;
      for (int b = 0; b < 8; b++) if (m[b]) s += (b >= 4) ? 2 : 1;
      return s;
   endfunction

   // {pull, user, mask, sp_in, sp_out}
   localparam logic [41:0] VEC [0:5] = '{
      {1'b0, 1'b0, 8'h01, 16'h0100, 16'h00FF},
      {1'b0, 1'b0, 8'h30, 16'h0100, 16'h00FC},
      {1'b0, 1'b1, 8'h0F, 16'h0200, 16'h01FC},
      {1'b1, 1'b1, 8'hC0, 16'h0300, 16'h0304},
      {1'b1, 1'b0, 8'hFF, 16'h0080, 16'h008C},
      {1'b0, 1'b0, 8'hFF, 16'h0050, 16'h0044}
   };

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int cyc;
      logic [15:0] p;
      logic [15:0] img [0:8];
      for (int i = 0; i <= 8; i++) regs[i] = 16'h0;
      repeat (3) @(negedge clk);
      chk(busy == 0 && done == 0 && mem_en == 0 && wr_en == 0, "R6 reset idle",
          {busy, done, mem_en, wr_en}, 0);
      rst_n = 1'b1;

      // table walk: R6 timing, R10 final pointer
      for (int v = 0; v < 6; v++) begin
         logic [41:0] e = VEC[v];
         poke(e[40] ? 6 : 8, e[31:16]);
         run_op(e[41], e[40], e[39:32], 1'b0, cyc);
         chk(cyc == nbytes(e[39:32]) + 1, "R6 done timing", cyc, nbytes(e[39:32]) + 1);
         chk(acc_cnt == nbytes(e[39:32]), "R6 access count", acc_cnt, nbytes(e[39:32]));
         chk(regs[e[40] ? 6 : 8] == e[15:0], "R10 final pointer", regs[e[40] ? 6 : 8], e[15:0]);
      end

      // full save on system stack: R1 R2 R3 R4 R7
      img[0] = 16'h0011; img[1] = 16'h0022; img[2] = 16'h0033; img[3] = 16'h0044;
      img[4] = 16'h5566; img[5] = 16'h7788; img[6] = 16'h99AA; img[7] = 16'hBBCC;
      for (int i = 0; i < 8; i++) poke(i, img[i]);
      poke(8, 16'h01F0);
      run_op(1'b0, 1'b0, 8'hFF, 1'b0, cyc);
      chk(first_addr == 16'h01EF, "R2 save starts at PC low", first_addr, 16'h01EF);
      chk(last_addr == 16'h01E4, "R2 save ends at CC", last_addr, 16'h01E4);
      p = 16'h01F0;
      for (int b = 7; b >= 0; b--) begin
         if (b >= 4) begin
            p = p - 16'd1;
            chk(mem[p[7:0]] == img[b][7:0], "R4 low byte above", mem[p[7:0]], img[b][7:0]);
            p = p - 16'd1;
            chk(mem[p[7:0]] == img[b][15:8], "R4 high byte below", mem[p[7:0]], img[b][15:8]);
         end else begin
            p = p - 16'd1;
            chk(mem[p[7:0]] == img[b][7:0], "R3 R1 byte slot", mem[p[7:0]], img[b][7:0]);
         end
      end
      chk(regs[8] == 16'h01E4, "R10 save pointer", regs[8], 16'h01E4);

      // clobber then restore: R5 R1 R7
      for (int i = 0; i < 8; i++) poke(i, 16'hDEAD);
      run_op(1'b1, 1'b0, 8'hFF, 1'b0, cyc);
      for (int i = 0; i < 8; i++)
         chk(regs[i] == img[i], "R5 restored register", regs[i], img[i]);
      chk(regs[8] == 16'h01F0, "R5 restore pointer", regs[8], 16'h01F0);

      // slot 6 on user stack names SSP: R7
      poke(6, 16'h0300);
      run_op(1'b0, 1'b1, 8'h40, 1'b0, cyc);
      chk(mem[8'hFF] == 8'hF0, "R7 other pointer low", mem[8'hFF], 8'hF0);
      chk(mem[8'hFE] == 8'h01, "R7 other pointer high", mem[8'hFE], 8'h01);
      chk(regs[6] == 16'h02FE, "R7 user pointer", regs[6], 16'h02FE);

      // wrap: R8
      poke(8, 16'h0001);
      run_op(1'b0, 1'b0, 8'h80, 1'b0, cyc);
      chk(mem[8'h00] == 8'hCC && mem[8'hFF] == 8'hBB, "R8 wrap save",
          {mem[8'h00], mem[8'hFF]}, 16'hCCBB);
      chk(regs[8] == 16'hFFFF, "R8 wrap pointer down", regs[8], 16'hFFFF);
      poke(7, 16'h0000);
      run_op(1'b1, 1'b0, 8'h80, 1'b0, cyc);
      chk(regs[7] == 16'hBBCC, "R8 wrap restore", regs[7], 16'hBBCC);
      chk(regs[8] == 16'h0001, "R8 wrap pointer up", regs[8], 16'h0001);

      // zero extension on one-byte restore: R5
      poke(8, 16'h0011);
      run_op(1'b0, 1'b0, 8'h04, 1'b0, cyc);
      poke(1, 16'hFFFF);
      run_op(1'b1, 1'b0, 8'h02, 1'b0, cyc);
      chk(regs[1] == 16'h0033, "R5 zero extend", regs[1], 16'h0033);

      // empty mask: R9
      poke(8, 16'h4242);
      run_op(1'b0, 1'b0, 8'h00, 1'b0, cyc);
      chk(cyc == 1, "R9 empty done timing", cyc, 1);
      chk(acc_cnt == 0, "R9 no access", acc_cnt, 0);
      chk(regs[8] == 16'h4242, "R9 pointer kept", regs[8], 16'h4242);

      // start while busy: R11
      poke(8, 16'h0040);
      run_op(1'b0, 1'b0, 8'h80, 1'b1, cyc);
      chk(cyc == 3, "R11 timing unchanged", cyc, 3);
      chk(acc_cnt == 2, "R11 access count", acc_cnt, 2);
      chk(regs[8] == 16'h003E, "R11 pointer", regs[8], 16'h003E);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule